// File: doc/BRIEF.md
# Queued SPI master sequencer

This block is a master-mode SPI engine that works through a list of transfer commands kept in a small on-chip queue memory. Each queue slot holds a transmit word, a receive word and a command entry made of chip-select bits and a continue flag. Software fills the queue, writes a start pointer and an end pointer, then sets the enable bit. From then on the engine issues one serial transfer per slot and stores each received word back into the slot it came from. It carries on without further help until it reaches the end slot.

The host sees one flat address space. It contains the three queue areas and a handful of control registers: control bits, start pointer, end pointer, sticky status flags, the index of the last completed slot, and an idle chip-select value. The host can halt the engine cleanly between transfers, resume it, or abort it outright. It can also ask the engine to loop back to slot 0 forever. If another device pulls the slave-select line low while that line is configured as a fault input, the engine shuts down and records a mode fault.

Top module: `qseq_top`

## Requirements
- R1: After reset the control register reads 0, the start and end pointers read 0, the status register reads 0, SCK is low and the chip-select outputs equal the idle value, which resets to all ones.
- R2: The host address is {segment[1:0], index}. Segment 0 is transmit words, 1 is receive words, 2 is commands and 3 is registers. A command entry reads back with the continue flag in bit 7 and the chip-select value in the low CS_W bits. Every queue location reads back what the host last wrote.
- R3: Register 0 holds control bits: bit0 enable, bit1 halt, bit2 wraparound, bit3 slave-select-as-fault-input. Register 1 is the start pointer and register 2 the end pointer. When enable is set, execution begins at the start-pointer slot and steps up one slot per transfer. Once the end slot completes, status bit0 (finished) is set, enable clears itself and register 4 reads the end index.
- R4: With both pointers left at their reset value of 0, enabling the engine runs exactly one transfer, from slot 0.
- R5: When a transfer ends, the word shifted in on MISO is written to the receive slot with the same index, zero-extended to 16 bits.
- R6: With wraparound set, completing the end slot continues at slot 0. Enable stays set and the finished flag stays clear.
- R7: Setting halt lets the current transfer finish. The engine then stops, sets status bit1 (halt acknowledge) and keeps enable set. Clearing halt resumes at the next slot.
- R8: While halted, the chip selects hold the last command's value if its continue flag was set. Otherwise they drive the idle value in register 5. When the engine is idle, they also drive the idle value.
- R9: A halt that is pending while the end slot runs sets both halt acknowledge and finished, and clears enable.
- R10: Clearing enable stops the engine at once, even mid-transfer. SCK returns low, the chip selects go to the idle value and the finished flag is not set.
- R11: If slave-select is configured as a fault input and is driven low while the engine is enabled, status bit2 (mode fault) is set and enable is cleared. When slave-select is not configured as a fault input, its level has no effect.
- R12: A frame is XFER_W bits, MSB first. SCK idles low. MOSI is valid before the first rising edge and MISO is sampled on rising edges. Throughout the frame the chip selects carry the slot's command value.
- R13: A start-pointer write while the engine runs lets the current transfer finish. The next transfer then uses the newly written slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | PW+2 | Host address: segment and index |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select line watched for mode fault |
| pcs | output | CS_W | Peripheral chip selects |

## Verification
The bench builds the block with 8-bit frames, a two-cycle SCK half period, a 16-slot queue and four chip selects. Short frames let several full queue runs fit in the cycle budget, including halt and resume, wraparound through slot 0, and mid-frame abort and fault. A pin-level monitor rebuilds every frame from MOSI on SCK rising edges and compares the data and chip selects against a queue of expected slots. A MOSI-to-MISO loopback, optionally inverted, makes the received words predictable.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_BUSY, ST_HALT} qseq_state_e;

  localparam logic [1:0] SEG_TX  = 2'd0;
  localparam logic [1:0] SEG_RX  = 2'd1;
  localparam logic [1:0] SEG_CMD = 2'd2;
  localparam logic [1:0] SEG_REG = 2'd3;

  localparam int REG_CTRL = 0;
  localparam int REG_NEWQ = 1;
  localparam int REG_ENDQ = 2;
  localparam int REG_STAT = 3;
  localparam int REG_CPTR = 4;
  localparam int REG_DFLT = 5;

  localparam int CB_EN   = 0;
  localparam int CB_HALT = 1;
  localparam int CB_WRAP = 2;
  localparam int CB_SSIN = 3;

  localparam int SB_DONE  = 0;
  localparam int SB_HACK  = 1;
  localparam int SB_FAULT = 2;
endpackage

// File: rtl/qseq_shifter.sv
module qseq_shifter #(
  parameter int W    = 16,
  parameter int HALF = 4,
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int BIT_W = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic [W-1:0] tx,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             ph_q, ph_d, busy_q, busy_d, done_q, done_d;
  logic [W-1:0]     sh_q, sh_d, rx_q, rx_d;

  always_comb begin
    cnt_d = cnt_q; bit_d = bit_q; ph_d = ph_q; busy_d = busy_q;
    sh_d = sh_q; rx_d = rx_q; done_d = 1'b0;
    if (abort) begin
      busy_d = 1'b0; ph_d = 1'b0; cnt_d = '0;
    end else if (start) begin
      busy_d = 1'b1; ph_d = 1'b0; cnt_d = '0; bit_d = '0; sh_d = tx;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(HALF - 1)) begin
        cnt_d = '0;
        if (!ph_q) begin
          ph_d = 1'b1;
          rx_d = {rx_q[W-2:0], miso};
        end else begin
          ph_d = 1'b0;
          if (bit_q == BIT_W'(W - 1)) begin
            busy_d = 1'b0; done_d = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = {sh_q[W-2:0], 1'b0};
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; bit_q <= '0; ph_q <= 1'b0; busy_q <= 1'b0;
      done_q <= 1'b0; sh_q <= '0; rx_q <= '0;
    end else begin
      cnt_q <= cnt_d; bit_q <= bit_d; ph_q <= ph_d; busy_q <= busy_d;
      done_q <= done_d; sh_q <= sh_d; rx_q <= rx_d;
    end
  end

  assign sck  = ph_q;
  assign mosi = busy_q & sh_q[W-1];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !ph_q); // R12
endmodule

// File: rtl/qseq_regs.sv
module qseq_regs import qseq_pkg::*; #(
  parameter int QDEPTH = 16,
  parameter int CS_W   = 4,
  localparam int PW = $clog2(QDEPTH),
  localparam int AW = PW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [15:0]   h_wdata,
  output logic [15:0]   h_rdata,
  input  logic [PW-1:0] eng_idx,
  output logic [15:0]   eng_tx,
  output logic [CS_W:0] eng_cmd,
  input  logic          rx_we,
  input  logic [15:0]   rx_data,
  input  logic          clr_en,
  input  logic          set_done,
  input  logic          set_hack,
  input  logic          set_fault,
  input  logic [PW-1:0] cptr,
  output logic          en,
  output logic          halt,
  output logic          wrap,
  output logic          ss_in,
  output logic [PW-1:0] newq,
  output logic [PW-1:0] endq,
  output logic          newq_wr,
  output logic [CS_W-1:0] dflt_cs
);
  logic [15:0]   tx_mem  [QDEPTH];
  logic [15:0]   rx_mem  [QDEPTH];
  logic [CS_W:0] cmd_mem [QDEPTH];

  logic [1:0]      seg;
  logic [PW-1:0]   idx;
  logic            wr_tx, wr_rx, wr_cmd, wr_ctrl, wr_newq, wr_endq, wr_stat, wr_dflt;
  logic [3:0]      ctrl_q, ctrl_d;
  logic [2:0]      stat_q, stat_d;
  logic [PW-1:0]   newq_q, newq_d, endq_q, endq_d;
  logic [CS_W-1:0] dflt_q, dflt_d;

  assign seg     = h_addr[AW-1:PW];
  assign idx     = h_addr[PW-1:0];
  assign wr_tx   = h_we && (seg == SEG_TX);
  assign wr_rx   = h_we && (seg == SEG_RX);
  assign wr_cmd  = h_we && (seg == SEG_CMD);
  assign wr_ctrl = h_we && (seg == SEG_REG) && (idx == PW'(REG_CTRL));
  assign wr_newq = h_we && (seg == SEG_REG) && (idx == PW'(REG_NEWQ));
  assign wr_endq = h_we && (seg == SEG_REG) && (idx == PW'(REG_ENDQ));
  assign wr_stat = h_we && (seg == SEG_REG) && (idx == PW'(REG_STAT));
  assign wr_dflt = h_we && (seg == SEG_REG) && (idx == PW'(REG_DFLT));

  always_ff @(posedge clk) begin
    if (wr_tx)  tx_mem[idx]  <= h_wdata;
    if (wr_cmd) cmd_mem[idx] <= {h_wdata[7], h_wdata[CS_W-1:0]};
    if (rx_we)      rx_mem[eng_idx] <= rx_data;
    else if (wr_rx) rx_mem[idx]     <= h_wdata;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = h_wdata[3:0];
    if (clr_en)  ctrl_d[CB_EN] = 1'b0;
    stat_d = stat_q;
    if (wr_stat)   stat_d = stat_q & ~h_wdata[2:0];
    if (set_done)  stat_d[SB_DONE]  = 1'b1;
    if (set_hack)  stat_d[SB_HACK]  = 1'b1;
    if (set_fault) stat_d[SB_FAULT] = 1'b1;
    newq_d = wr_newq ? h_wdata[PW-1:0]   : newq_q;
    endq_d = wr_endq ? h_wdata[PW-1:0]   : endq_q;
    dflt_d = wr_dflt ? h_wdata[CS_W-1:0] : dflt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; stat_q <= '0; newq_q <= '0; endq_q <= '0; dflt_q <= '1;
    end else begin
      ctrl_q <= ctrl_d; stat_q <= stat_d; newq_q <= newq_d;
      endq_q <= endq_d; dflt_q <= dflt_d;
    end
  end

  always_comb begin
    h_rdata = '0;
    case (seg)
      SEG_TX:  h_rdata = tx_mem[idx];
      SEG_RX:  h_rdata = rx_mem[idx];
      SEG_CMD: begin
        h_rdata[7]        = cmd_mem[idx][CS_W];
        h_rdata[CS_W-1:0] = cmd_mem[idx][CS_W-1:0];
      end
      default: begin
        if (idx == PW'(REG_CTRL)) h_rdata[3:0] = ctrl_q;
        if (idx == PW'(REG_NEWQ)) h_rdata[PW-1:0] = newq_q;
        if (idx == PW'(REG_ENDQ)) h_rdata[PW-1:0] = endq_q;
        if (idx == PW'(REG_STAT)) h_rdata[2:0] = stat_q;
        if (idx == PW'(REG_CPTR)) h_rdata[PW-1:0] = cptr;
        if (idx == PW'(REG_DFLT)) h_rdata[CS_W-1:0] = dflt_q;
      end
    endcase
  end

  assign eng_tx  = tx_mem[eng_idx];
  assign eng_cmd = cmd_mem[eng_idx];
  assign en      = ctrl_q[CB_EN];
  assign halt    = ctrl_q[CB_HALT];
  assign wrap    = ctrl_q[CB_WRAP];
  assign ss_in   = ctrl_q[CB_SSIN];
  assign newq    = newq_q;
  assign endq    = endq_q;
  assign newq_wr = wr_newq;
  assign dflt_cs = dflt_q;
endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl import qseq_pkg::*; #(
  parameter int QDEPTH = 16,
  parameter int CS_W   = 4,
  localparam int PW = $clog2(QDEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            halt,
  input  logic            wrap,
  input  logic            ss_in,
  input  logic            ss_n,
  input  logic [PW-1:0]   newq,
  input  logic [PW-1:0]   endq,
  input  logic            newq_wr,
  input  logic [CS_W:0]   cmd,
  input  logic [CS_W-1:0] dflt_cs,
  input  logic            sh_busy,
  input  logic            sh_done,
  output logic [PW-1:0]   ptr,
  output logic            sh_start,
  output logic            sh_abort,
  output logic            rx_we,
  output logic            clr_en,
  output logic            set_done,
  output logic            set_hack,
  output logic            set_fault,
  output logic [PW-1:0]   cptr,
  output logic [CS_W-1:0] pcs
);
  qseq_state_e     state_q, state_d;
  logic [PW-1:0]   ptr_q, ptr_d, cptr_q, cptr_d, nxt_ptr;
  logic            reload_q, reload_d, cont_q, cont_d;
  logic [CS_W-1:0] cs_q, cs_d, pcs_q, pcs_d;
  logic            fault_evt, stop, hit;

  assign fault_evt = en & ss_in & ~ss_n;
  assign stop      = ~en | fault_evt;
  assign hit       = (ptr_q == endq);
  assign nxt_ptr   = reload_q ? newq : (hit ? '0 : ptr_q + 1'b1);

  always_comb begin
    state_d = state_q; ptr_d = ptr_q; cptr_d = cptr_q;
    reload_d = reload_q | newq_wr; cont_d = cont_q; cs_d = cs_q; pcs_d = pcs_q;
    sh_start = 1'b0; rx_we = 1'b0; clr_en = 1'b0;
    set_done = 1'b0; set_hack = 1'b0; set_fault = fault_evt;
    if (stop) begin
      state_d = ST_IDLE; pcs_d = dflt_cs; reload_d = 1'b0; clr_en = fault_evt;
    end else begin
      case (state_q)
        ST_IDLE: begin
          pcs_d = dflt_cs; reload_d = 1'b0; ptr_d = newq; state_d = ST_ISSUE;
        end
        ST_ISSUE: begin
          sh_start = 1'b1;
          cs_d     = cmd[CS_W-1:0];
          cont_d   = cmd[CS_W];
          pcs_d    = cmd[CS_W-1:0];
          state_d  = ST_BUSY;
        end
        ST_BUSY: begin
          if (sh_done) begin
            rx_we    = 1'b1;
            cptr_d   = ptr_q;
            pcs_d    = cont_q ? cs_q : dflt_cs;
            reload_d = newq_wr;
            set_hack = halt;
            if (hit && !wrap) begin
              set_done = 1'b1; clr_en = 1'b1; state_d = ST_IDLE;
            end else begin
              ptr_d   = nxt_ptr;
              state_d = halt ? ST_HALT : ST_ISSUE;
            end
          end
        end
        default: begin
          if (!halt) begin
            state_d = ST_ISSUE;
            if (reload_q) begin
              ptr_d = newq; reload_d = newq_wr;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ptr_q <= '0; cptr_q <= '0; reload_q <= 1'b0;
      cont_q <= 1'b0; cs_q <= '0; pcs_q <= '1;
    end else begin
      state_q <= state_d; ptr_q <= ptr_d; cptr_q <= cptr_d; reload_q <= reload_d;
      cont_q <= cont_d; cs_q <= cs_d; pcs_q <= pcs_d;
    end
  end

  assign ptr      = ptr_q;
  assign sh_abort = stop;
  assign cptr     = cptr_q;
  assign pcs      = pcs_q;

  AST_END_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fault_evt && state_q == ST_BUSY && sh_done && hit && !wrap) |=> !en); // R3
  AST_FAULT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> !en); // R11
  AST_HALT_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |-> !sh_busy); // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> !sh_busy); // R10
endmodule

// File: rtl/qseq_top.sv
module qseq_top #(
  parameter int QDEPTH   = 16,
  parameter int XFER_W   = 16,
  parameter int HALF_DIV = 4,
  parameter int CS_W     = 4,
  localparam int PW = $clog2(QDEPTH),
  localparam int AW = PW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_we,
  input  logic [AW-1:0]   h_addr,
  input  logic [15:0]     h_wdata,
  output logic [15:0]     h_rdata,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  input  logic            ss_n,
  output logic [CS_W-1:0] pcs
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [PW-1:0]     eng_idx, newq, endq, cptr;
  logic [15:0]       eng_tx;
  logic [CS_W:0]     eng_cmd;
  logic              rx_we, clr_en, set_done, set_hack, set_fault;
  logic              en, halt, wrap, ss_in, newq_wr;
  logic [CS_W-1:0]   dflt_cs;
  logic              sh_start, sh_abort, sh_busy, sh_done;
  logic [XFER_W-1:0] sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  qseq_regs #(.QDEPTH(QDEPTH), .CS_W(CS_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .eng_idx(eng_idx), .eng_tx(eng_tx), .eng_cmd(eng_cmd),
    .rx_we(rx_we), .rx_data(16'(sh_rx)), .clr_en(clr_en), .set_done(set_done),
    .set_hack(set_hack), .set_fault(set_fault), .cptr(cptr), .en(en), .halt(halt),
    .wrap(wrap), .ss_in(ss_in), .newq(newq), .endq(endq), .newq_wr(newq_wr),
    .dflt_cs(dflt_cs));

  qseq_ctrl #(.QDEPTH(QDEPTH), .CS_W(CS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .en(en), .halt(halt), .wrap(wrap), .ss_in(ss_in),
    .ss_n(ss_n), .newq(newq), .endq(endq), .newq_wr(newq_wr), .cmd(eng_cmd),
    .dflt_cs(dflt_cs), .sh_busy(sh_busy), .sh_done(sh_done), .ptr(eng_idx),
    .sh_start(sh_start), .sh_abort(sh_abort), .rx_we(rx_we), .clr_en(clr_en),
    .set_done(set_done), .set_hack(set_hack), .set_fault(set_fault),
    .cptr(cptr), .pcs(pcs));

  qseq_shifter #(.W(XFER_W), .HALF(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_s_n), .start(sh_start), .abort(sh_abort),
    .tx(eng_tx[XFER_W-1:0]), .miso(miso), .sck(sck), .mosi(mosi),
    .busy(sh_busy), .done(sh_done), .rx(sh_rx));
endmodule

// File: tb/tb_qseq_top.sv
module tb_qseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int HALF = 2;
  localparam int QD = 16;
  localparam int CSW = 4;
  localparam logic [5:0] A_CTRL = 6'h30, A_NEWQ = 6'h31, A_ENDQ = 6'h32,
                         A_STAT = 6'h33, A_CPTR = 6'h34, A_DFLT = 6'h35;

  logic clk, rst_n, h_we, miso, ss_n, sck, mosi, inv;
  logic [5:0] h_addr;
  logic [15:0] h_wdata, h_rdata;
  logic [CSW-1:0] pcs;

  int checks = 0, errors = 0, mbits = 0, frames_seen = 0;
  logic [W-1:0] mword;
  logic [11:0] exp_q[$];
  logic [3:0] dflt = 4'hF;

  qseq_top #(.QDEPTH(QD), .XFER_W(W), .HALF_DIV(HALF), .CS_W(CSW)) dut (
    .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .pcs(pcs));

  assign miso = inv ? ~mosi : mosi;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [7:0] txb(input int i);
    return 8'((i * 37) ^ 8'h3C);
  endfunction
  function automatic logic [3:0] csv(input int i);
    return 4'hF & ~(4'b1 << (i % 4));
  endfunction
  function automatic logic contv(input int i);
    return (i % 2) == 0;
  endfunction

  task automatic push(input int i);
    exp_q.push_back({csv(i), txb(i)});
  endtask

  task automatic hw(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic hr(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); h_addr = a; #1; d = h_rdata;
  endtask

  task automatic set_ctrl(input logic ssin, input logic wr, input logic hl, input logic e);
    hw(A_CTRL, {12'd0, ssin, wr, hl, e});
  endtask

  task automatic wait_done(input string tag);
    logic [15:0] s;
    int n = 0;
    do begin hr(A_STAT, s); n++; end while (!s[0] && n < 4000);
    chk(s[0], tag, s, 1);
  endtask

  // Scoreboard monitor: rebuilds frames at the pins on SCK rising edges.
  always @(posedge sck) begin : mon
    logic [11:0] e;
    mword = {mword[W-2:0], mosi};
    mbits++;
    if (mbits == W) begin
      mbits = 0;
      frames_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected frame", {pcs, mword}, 0);
      else begin
        e = exp_q.pop_front();
        chk({pcs, mword} == e, "R12 frame data and chip select", {pcs, mword}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int base;
    rst_n = 1'b0; h_we = 1'b0; h_addr = '0; h_wdata = '0; ss_n = 1'b1; inv = 1'b0;
    mword = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(sck == 1'b0, "R1 sck low", sck, 0);
    chk(pcs == 4'hF, "R1 chip selects idle", pcs, 4'hF);
    hr(A_CTRL, d); chk(d == 0, "R1 control", d, 0);
    hr(A_NEWQ, d); chk(d == 0, "R1 start pointer", d, 0);
    hr(A_ENDQ, d); chk(d == 0, "R1 end pointer", d, 0);
    hr(A_STAT, d); chk(d == 0, "R1 status", d, 0);

    for (int i = 0; i < QD; i++) begin
      hw(6'(i), {8'(i ^ 8'hA0), txb(i)});
      hw(6'h20 + 6'(i), {8'h00, contv(i), 3'b000, csv(i)});
      hw(6'h10 + 6'(i), 16'h0000);
    end
    // R2 host access
    hr(6'h03, d); chk(d == {8'h03 ^ 8'hA0, txb(3)}, "R2 tx readback", d, {8'hA3, txb(3)});
    hr(6'h25, d); chk(d == {8'h00, 1'b0, 3'b000, csv(5)}, "R2 cmd readback", d, csv(5));
    hr(6'h14, d); chk(d == 16'h0000, "R2 rx readback", d, 0);

    // R4 default pointers run only slot 0
    push(0);
    set_ctrl(0, 0, 0, 1);
    wait_done("R4 finished");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 single frame", exp_q.size(), 0);
    hr(A_CPTR, d); chk(d == 0, "R4 completed index", d, 0);
    hr(A_CTRL, d); chk(d[0] == 1'b0, "R4 enable cleared", d, 0);
    hr(6'h10, d); chk(d == {8'h00, txb(0)}, "R5 rx loopback", d, txb(0));

    // R3 run 2..5, slave-select low but not a fault input (R11 ignored case)
    hw(A_STAT, 16'h7);
    ss_n = 1'b0; inv = 1'b1;
    hw(A_NEWQ, 16'd2); hw(A_ENDQ, 16'd5);
    for (int i = 2; i <= 5; i++) push(i);
    set_ctrl(0, 0, 0, 1);
    wait_done("R3 finished");
    chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
    hr(A_CPTR, d); chk(d == 5, "R3 completed index", d, 5);
    hr(A_CTRL, d); chk(d[0] == 1'b0, "R3 enable cleared", d, 0);
    hr(A_STAT, d); chk(d[2] == 1'b0, "R11 no fault when not fault input", d, 0);
    hr(6'h13, d); chk(d == {8'h00, ~txb(3)}, "R5 rx inverted", d, ~txb(3));
    ss_n = 1'b1; inv = 1'b0;

    // R13 start pointer reload mid-run
    hw(A_STAT, 16'h7);
    hw(A_NEWQ, 16'd0); hw(A_ENDQ, 16'd7);
    push(0); push(5); push(6); push(7);
    set_ctrl(0, 0, 0, 1);
    repeat (10) @(negedge clk);
    hw(A_NEWQ, 16'd5);
    wait_done("R13 finished");
    chk(exp_q.size() == 0, "R13 jump after current frame", exp_q.size(), 0);
    hr(A_CPTR, d); chk(d == 7, "R13 completed index", d, 7);

    // R6 wraparound
    hw(A_STAT, 16'h7);
    hw(A_NEWQ, 16'd1); hw(A_ENDQ, 16'd2);
    push(1); push(2); push(0); push(1); push(2);
    base = frames_seen;
    set_ctrl(0, 1, 0, 1);
    while (frames_seen < base + 3) @(negedge clk);
    hr(A_STAT, d); chk(d[0] == 1'b0, "R6 no finish while wrapping", d, 0);
    hr(A_CTRL, d); chk(d[0] == 1'b1, "R6 enable kept", d, 1);
    set_ctrl(0, 0, 0, 1);
    wait_done("R6 finished after wrap off");
    chk(exp_q.size() == 0, "R6 wrapped through slot 0", exp_q.size(), 0);

    // R7 and R8 halt at boundary
    hw(A_STAT, 16'h7);
    dflt = 4'hA; hw(A_DFLT, 16'h000A);
    hw(A_NEWQ, 16'd0); hw(A_ENDQ, 16'd3);
    for (int i = 0; i < 4; i++) push(i);
    set_ctrl(0, 0, 0, 1);
    repeat (10) @(negedge clk);
    set_ctrl(0, 0, 1, 1);
    repeat (60) @(negedge clk);
    hr(A_STAT, d); chk(d[1:0] == 2'b10, "R7 halt ack without finish", d, 2);
    hr(A_CTRL, d); chk(d[0] == 1'b1, "R7 enable kept", d, 1);
    chk(exp_q.size() == 3, "R7 stopped after one frame", exp_q.size(), 3);
    chk(pcs == csv(0), "R8 held chip select", pcs, csv(0));
    chk(sck == 1'b0, "R7 sck idle while halted", sck, 0);
    hw(A_STAT, 16'h2);
    set_ctrl(0, 0, 0, 1);
    repeat (12) @(negedge clk);
    set_ctrl(0, 0, 1, 1);
    repeat (60) @(negedge clk);
    hr(A_STAT, d); chk(d[1] == 1'b1, "R7 second halt ack", d, 2);
    chk(exp_q.size() == 2, "R7 resumed at next slot", exp_q.size(), 2);
    chk(pcs == dflt, "R8 idle value after non-continue", pcs, dflt);
    set_ctrl(0, 0, 0, 1);
    wait_done("R7 finished after resume");
    chk(exp_q.size() == 0, "R7 remaining frames", exp_q.size(), 0);
    chk(pcs == dflt, "R8 idle value when stopped", pcs, dflt);

    // R9 halt pending on end slot
    hw(A_STAT, 16'h7);
    hw(A_NEWQ, 16'd4); hw(A_ENDQ, 16'd4);
    push(4);
    set_ctrl(0, 0, 0, 1);
    repeat (10) @(negedge clk);
    set_ctrl(0, 0, 1, 1);
    repeat (60) @(negedge clk);
    hr(A_STAT, d); chk(d[1:0] == 2'b11, "R9 both flags", d, 3);
    hr(A_CTRL, d); chk(d[0] == 1'b0, "R9 enable cleared", d, 0);
    chk(exp_q.size() == 0, "R9 last frame done", exp_q.size(), 0);
    set_ctrl(0, 0, 0, 0);

    // R10 immediate abort
    hw(A_STAT, 16'h7);
    hw(A_NEWQ, 16'd0); hw(A_ENDQ, 16'd15);
    set_ctrl(0, 0, 0, 1);
    repeat (12) @(negedge clk);
    set_ctrl(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(sck == 1'b0, "R10 sck low after abort", sck, 0);
    chk(pcs == dflt, "R10 chip selects idle", pcs, dflt);
    hr(A_STAT, d); chk(d[0] == 1'b0, "R10 no finish", d, 0);
    mbits = 0;
    base = frames_seen;
    repeat (100) @(negedge clk);
    chk(frames_seen == base && mbits == 0, "R10 no further clocks", mbits, 0);

    // R11 mode fault
    hw(A_STAT, 16'h7);
    set_ctrl(1, 0, 0, 1);
    repeat (12) @(negedge clk);
    ss_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sck == 1'b0, "R11 sck low after fault", sck, 0);
    hr(A_STAT, d); chk(d[2] == 1'b1, "R11 fault flag", d, 4);
    hr(A_CTRL, d); chk(d[0] == 1'b0, "R11 enable cleared", d, 0);
    mbits = 0;
    ss_n = 1'b1;
    repeat (5) @(negedge clk);

    summary();
    $finish;
  end
endmodule